// File: doc/BRIEF.md
# Key-Scanner Link Resync and Status Poll Sequencer

This block is the host-side command sequencer for a key-scanning slave reached over a full-duplex serial byte link. It sits above a byte engine that moves one byte each way per transfer and handles the slave's ready handshake. The sequencer decides which byte goes out next and interprets what comes back. Because the link is full duplex, the reply to a command arrives during the following transfer. The sequencer therefore sends a null byte (0x00) after each command to collect the reply.

After reset, and whenever a reply does not make sense, the sequencer treats the link as out of step. It sends the resync command 0x0F repeatedly until a received byte equals 0xF0, the bitwise complement of that command. It then polls at a fixed tick-based period with the first-key status command 0x06. The decoded status steers what follows:
- If the error flag is set, the two error-query commands 0x0B and 0x0C follow.
- If the multiple-keys flag is set, the multi-key command 0x07 follows, and its multi-byte answer is streamed back to back.

Key index, flags, error codes and the key bitmap are presented on output ports, together with a one-cycle update strobe.

Top module: `kps_link_seq`

## Requirements
- R1: While out of sync, every transfer requested carries 0x0F. `in_sync` rises in the cycle after a transfer completes with received byte exactly 0xF0. Any other received byte, including 0x0F and 0xF1, leaves the sequencer resyncing.
- R2: During and right after reset: `in_sync`=0, `lost_sync`=0, `key_idx`=all ones (31 by default), error codes and bitmap are 0, and `xfer_req`=1 with `xfer_tx`=0x0F.
- R3: The 0x06 command is started only once at least POLL_TICKS `tick` pulses (default 25) have arrived since the previous 0x06 was started. A POLL_TICKS below MIN_POLL_TICKS (10) is rejected at elaboration.
- R4: Each command is followed by one 0x00 transfer, and the byte received during that transfer is the reply. The status reply is decoded as follows:
  - bit 7: error flag
  - bit 6: multiple-keys flag
  - bits 4:0: key index, where 31 means no key

  The decoded values appear on `err_flag`, `multi_flag` and `key_idx`.
- R5: With the error flag set, the poll continues with 0x0B, 0x00, 0x0C, 0x00. The two replies appear on `err_code_a` and `err_code_b`. Both codes hold their old values when a poll has no error.
- R6: With the multiple-keys flag set, the sequencer sends 0x07 followed by MULTI_BYTES (3) null transfers, back to back with no tick needed. The first reply byte lands in `key_mask[7:0]`. When both flags are set, the error queries come first. With the flag clear, `key_mask` holds.
- R7: A poll ends with a one-cycle `status_upd` pulse, one cycle after its last transfer. Nothing is sent between that point and the next due poll.
- R8: A status reply is invalid if either of these holds:
  - its key index is at least NUM_KEYS (24) and is not 31;
  - its reserved bit 5 is set.

  An invalid reply drops `in_sync`, sets `lost_sync` and returns the sequencer to sending 0x0F. No `status_upd` is given and `key_idx` is unchanged.
- R9: `lost_sync` stays set until reset, through later resync and polls.
- R10: Once `xfer_req` is high it stays high with `xfer_tx` unchanged until `xfer_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick | input | 1 | Poll timing tick, one cycle wide |
| xfer_req | output | 1 | Byte transfer request to the byte engine |
| xfer_tx | output | 8 | Byte to send |
| xfer_done | input | 1 | Transfer complete, one cycle wide |
| xfer_rx | input | 8 | Byte received in the completed transfer |
| in_sync | output | 1 | Link is in step with the slave |
| lost_sync | output | 1 | Sticky flag: a run-mode reply was invalid |
| status_upd | output | 1 | One-cycle pulse: a poll finished |
| key_idx | output | KEY_W | First detected key, all ones for none |
| err_flag | output | 1 | Error flag of the last status |
| multi_flag | output | 1 | Multiple-keys flag of the last status |
| err_code_a | output | 8 | Reply to 0x0B |
| err_code_b | output | 8 | Reply to 0x0C |
| key_mask | output | 8*MULTI_BYTES | Reply to 0x07, first byte lowest |

## Verification
The assertions assume that the byte engine raises `xfer_done` only while `xfer_req` is high, pulses it for a single cycle per transfer, and presents `xfer_rx` valid in that same cycle. The bench's engine model keeps to this rule. It waits a random 0 to 2 cycles after seeing a request, then pulses done once and drops it in the next cycle. Ticks are one-cycle pulses spaced four cycles apart. They are switched off during reset and the first resync, so the first poll cannot begin before the bench has staged its reply. They are also switched off partway through one poll, to show that follow-up commands need no tick.

// File: rtl/kps_pkg.sv
package kps_pkg;
   localparam logic [7:0] CMD_RESYNC = 8'h0F;
   localparam logic [7:0] SYNC_ECHO  = 8'hF0;
   localparam logic [7:0] CMD_STATUS = 8'h06;
   localparam logic [7:0] CMD_MULTI  = 8'h07;
   localparam logic [7:0] CMD_ERR_A  = 8'h0B;
   localparam logic [7:0] CMD_ERR_B  = 8'h0C;
   localparam logic [7:0] CMD_NULL   = 8'h00;

   typedef enum logic [3:0] {
      ST_RESYNC,
      ST_IDLE,
      ST_POLL_CMD,
      ST_POLL_RSP,
      ST_ERRA_CMD,
      ST_ERRA_RSP,
      ST_ERRB_CMD,
      ST_ERRB_RSP,
      ST_MULTI_CMD,
      ST_MULTI_RSP
   } seq_state_e;
endpackage

// File: rtl/kps_poll_timer.sv
module kps_poll_timer #(
   parameter int POLL_TICKS     = 25,
   parameter int MIN_POLL_TICKS = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic restart,
   output logic due
);
   localparam int CW = $clog2(POLL_TICKS + 1);
   localparam logic [CW-1:0] LIMIT = CW'(POLL_TICKS);

   if (POLL_TICKS < MIN_POLL_TICKS) begin : g_bad_period
      $error("poll period below minimum spacing");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (restart) begin
         cnt <= '0;
      end else if (tick && cnt != LIMIT) begin
         cnt <= cnt + 1'b1;
      end
   end

   assign due = (cnt == LIMIT);

   AST_POLL_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      restart |-> due);  // R3
   AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!restart && !tick) |=> $stable(cnt));  // R3
endmodule

// File: rtl/kps_status_decode.sv
module kps_status_decode #(
   parameter int KEY_W     = 5,
   parameter int NUM_KEYS  = 24,
   parameter int ERR_BIT   = 7,
   parameter int MULTI_BIT = 6
) (
   input  logic [7:0]       stat,
   output logic             err,
   output logic             multi,
   output logic [KEY_W-1:0] idx,
   output logic             bad
);
   localparam int NONE_CODE = (1 << KEY_W) - 1;
   localparam logic [KEY_W-1:0] NONE_IDX = KEY_W'(NONE_CODE);
   localparam logic [7:0] USED = (8'(1) << ERR_BIT) | (8'(1) << MULTI_BIT)
                                 | 8'(NONE_CODE);

   if (ERR_BIT == MULTI_BIT || ERR_BIT < KEY_W || MULTI_BIT < KEY_W
       || ERR_BIT > 7 || MULTI_BIT > 7) begin : g_bad_bits
      $error("status flag positions overlap the index or each other");
   end
   if (NUM_KEYS < 1 || NUM_KEYS > NONE_CODE) begin : g_bad_keys
      $error("key count does not fit the index field");
   end

   logic rsv_set;
   logic range_bad;

   assign err     = stat[ERR_BIT];
   assign multi   = stat[MULTI_BIT];
   assign idx     = stat[KEY_W-1:0];
   assign rsv_set = |(stat & ~USED);

   if (NUM_KEYS == NONE_CODE) begin : g_full_range
      assign range_bad = 1'b0;
   end else begin : g_part_range
      localparam logic [KEY_W-1:0] LAST_KEY = KEY_W'(NUM_KEYS - 1);
      assign range_bad = (idx > LAST_KEY) && (idx != NONE_IDX);
   end

   assign bad = rsv_set | range_bad;

   always_comb begin
      AST_BAD_MEANS_NONZERO: assert (!bad || stat != 8'h00);  // R8
   end
endmodule

// File: rtl/kps_burst_collect.sv
module kps_burst_collect #(
   parameter int BYTES = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear,
   input  logic               take,
   input  logic [7:0]         din,
   output logic [BYTES*8-1:0] data,
   output logic               last
);
   localparam int W  = BYTES * 8;
   localparam int CW = (BYTES > 1) ? $clog2(BYTES) : 1;
   localparam logic [CW-1:0] LAST_POS = CW'(BYTES - 1);

   if (BYTES < 1) begin : g_bad_bytes
      $error("burst length must be at least one byte");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clear) begin
         cnt <= '0;
      end else if (take && !last) begin
         cnt <= cnt + 1'b1;
      end
   end

   assign last = (cnt == LAST_POS);

   if (BYTES == 1) begin : g_single
      always_ff @(posedge clk) begin
         if (!rst_n)    data <= '0;
         else if (take) data <= din;
      end
   end else begin : g_shift
      always_ff @(posedge clk) begin
         if (!rst_n)    data <= '0;
         else if (take) data <= {din, data[W-1:8]};
      end
   end

   AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
      (take && last) |=> (cnt == LAST_POS) || $past(clear));  // R6
endmodule

// File: rtl/kps_link_seq.sv
module kps_link_seq #(
   parameter int NUM_KEYS       = 24,
   parameter int KEY_W          = 5,
   parameter int ERR_BIT        = 7,
   parameter int MULTI_BIT      = 6,
   parameter int MULTI_BYTES    = 3,
   parameter int POLL_TICKS     = 25,
   parameter int MIN_POLL_TICKS = 10
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     tick,
   output logic                     xfer_req,
   output logic [7:0]               xfer_tx,
   input  logic                     xfer_done,
   input  logic [7:0]               xfer_rx,
   output logic                     in_sync,
   output logic                     lost_sync,
   output logic                     status_upd,
   output logic [KEY_W-1:0]         key_idx,
   output logic                     err_flag,
   output logic                     multi_flag,
   output logic [7:0]               err_code_a,
   output logic [7:0]               err_code_b,
   output logic [MULTI_BYTES*8-1:0] key_mask
);
   import kps_pkg::*;

   localparam logic [KEY_W-1:0] NONE_IDX = '1;

   seq_state_e st, st_nx;
   logic       due, restart;
   logic       d_err, d_multi, d_bad;
   logic [KEY_W-1:0] d_idx;
   logic       burst_last, burst_clear, burst_take;
   logic       stat_ok, poll_end;

   kps_poll_timer #(
      .POLL_TICKS(POLL_TICKS), .MIN_POLL_TICKS(MIN_POLL_TICKS)
   ) u_timer (
      .clk(clk), .rst_n(rst_n), .tick(tick), .restart(restart), .due(due)
   );

   kps_status_decode #(
      .KEY_W(KEY_W), .NUM_KEYS(NUM_KEYS), .ERR_BIT(ERR_BIT), .MULTI_BIT(MULTI_BIT)
   ) u_dec (
      .stat(xfer_rx), .err(d_err), .multi(d_multi), .idx(d_idx), .bad(d_bad)
   );

   kps_burst_collect #(.BYTES(MULTI_BYTES)) u_burst (
      .clk(clk), .rst_n(rst_n), .clear(burst_clear), .take(burst_take),
      .din(xfer_rx), .data(key_mask), .last(burst_last)
   );

   // Outgoing byte is a pure function of the state, so it is stable while waiting.
   always_comb begin
      case (st)
         ST_RESYNC:    xfer_tx = CMD_RESYNC;
         ST_POLL_CMD:  xfer_tx = CMD_STATUS;
         ST_ERRA_CMD:  xfer_tx = CMD_ERR_A;
         ST_ERRB_CMD:  xfer_tx = CMD_ERR_B;
         ST_MULTI_CMD: xfer_tx = CMD_MULTI;
         default:      xfer_tx = CMD_NULL;
      endcase
   end

   assign xfer_req = (st != ST_IDLE);
   assign in_sync  = (st != ST_RESYNC);

   always_comb begin
      st_nx = st;
      case (st)
         ST_RESYNC:    if (xfer_done && xfer_rx == SYNC_ECHO) st_nx = ST_IDLE;
         ST_IDLE:      if (due) st_nx = ST_POLL_CMD;
         ST_POLL_CMD:  if (xfer_done) st_nx = ST_POLL_RSP;
         ST_POLL_RSP:
            if (xfer_done) begin
               if (d_bad)        st_nx = ST_RESYNC;
               else if (d_err)   st_nx = ST_ERRA_CMD;
               else if (d_multi) st_nx = ST_MULTI_CMD;
               else              st_nx = ST_IDLE;
            end
         ST_ERRA_CMD:  if (xfer_done) st_nx = ST_ERRA_RSP;
         ST_ERRA_RSP:  if (xfer_done) st_nx = ST_ERRB_CMD;
         ST_ERRB_CMD:  if (xfer_done) st_nx = ST_ERRB_RSP;
         ST_ERRB_RSP:  if (xfer_done) st_nx = multi_flag ? ST_MULTI_CMD : ST_IDLE;
         ST_MULTI_CMD: if (xfer_done) st_nx = ST_MULTI_RSP;
         ST_MULTI_RSP: if (xfer_done && burst_last) st_nx = ST_IDLE;
         default:      st_nx = ST_RESYNC;
      endcase
   end

   assign restart     = (st == ST_IDLE) && due;
   assign burst_clear = (st == ST_MULTI_CMD) && xfer_done;
   assign burst_take  = (st == ST_MULTI_RSP) && xfer_done;
   assign stat_ok     = (st == ST_POLL_RSP) && xfer_done && !d_bad;
   assign poll_end    = xfer_done && (
                          ((st == ST_POLL_RSP) && !d_bad && !d_err && !d_multi)
                       || ((st == ST_ERRB_RSP) && !multi_flag)
                       || ((st == ST_MULTI_RSP) && burst_last));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st         <= ST_RESYNC;
         lost_sync  <= 1'b0;
         status_upd <= 1'b0;
         key_idx    <= NONE_IDX;
         err_flag   <= 1'b0;
         multi_flag <= 1'b0;
         err_code_a <= '0;
         err_code_b <= '0;
      end else begin
         st         <= st_nx;
         status_upd <= poll_end;
         if ((st == ST_POLL_RSP) && xfer_done && d_bad) lost_sync <= 1'b1;
         if (stat_ok) begin
            key_idx    <= d_idx;
            err_flag   <= d_err;
            multi_flag <= d_multi;
         end
         if ((st == ST_ERRA_RSP) && xfer_done) err_code_a <= xfer_rx;
         if ((st == ST_ERRB_RSP) && xfer_done) err_code_b <= xfer_rx;
      end
   end

   AST_SYNC_ON_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_sync) |-> $past(xfer_done && xfer_rx == SYNC_ECHO));  // R1
   AST_STAY_UNSYNCED: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_sync && !(xfer_done && xfer_rx == SYNC_ECHO)) |=> !in_sync);  // R1
   AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_req && !xfer_done) |=> (xfer_req && $stable(xfer_tx)));  // R10
   AST_LOST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      lost_sync |=> lost_sync);  // R9
   AST_LOSS_DROPS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lost_sync) |-> !in_sync);  // R8
   AST_UPD_SYNCED: assert property (@(posedge clk) disable iff (!rst_n)
      status_upd |-> (in_sync && !xfer_req));  // R7
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!xfer_req && !due) |=> !xfer_req);  // R7
endmodule

// File: tb/sim_kps_link_seq.sv
module sim_kps_link_seq;
   localparam int NK = 24;
   localparam int P  = 25;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0;
   logic xfer_req, xfer_done = 1'b0;
   logic [7:0] xfer_tx, xfer_rx = 8'h00;
   logic in_sync, lost_sync, status_upd, err_flag, multi_flag;
   logic [4:0] key_idx;
   logic [7:0] err_code_a, err_code_b;
   logic [23:0] key_mask;

   kps_link_seq u0 (
      .clk(clk), .rst_n(rst_n), .tick(tick), .xfer_req(xfer_req), .xfer_tx(xfer_tx),
      .xfer_done(xfer_done), .xfer_rx(xfer_rx), .in_sync(in_sync), .lost_sync(lost_sync),
      .status_upd(status_upd), .key_idx(key_idx), .err_flag(err_flag),
      .multi_flag(multi_flag), .err_code_a(err_code_a), .err_code_b(err_code_b),
      .key_mask(key_mask)
   );

   always #10 clk = ~clk;

   int nchk = 0, nerr = 0;
   logic [7:0] lg [0:31];
   int loglen = 0;
   logic [7:0] pending = 8'h0F;
   int deaf_left = 3;
   int sidx = 0;
   logic [7:0] sc_status = 8'h1F, sc_ea = 8'h00, sc_eb = 8'h00;
   logic [7:0] sc_m [0:2];
   bit tick_en = 1'b0;
   int ticks = 0, prev_ticks = 0, div = 0;
   bit have_prev = 1'b0, seen06 = 1'b0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic reply(input logic [7:0] t);
      if (deaf_left > 0) begin
         pending = deaf_left[0] ? 8'hF1 : 8'h0F;
         deaf_left--;
      end else begin
         case (t)
            8'h0F: begin pending = 8'hF0; sidx = 0; end
            8'h06: begin pending = sc_status; sidx = 0; end
            8'h07: begin pending = sc_m[0]; sidx = 1; end
            8'h0B: begin pending = sc_ea; sidx = 0; end
            8'h0C: begin pending = sc_eb; sidx = 0; end
            8'h00: begin
               if (sidx > 0 && sidx < 3) begin pending = sc_m[sidx]; sidx++; end
               else begin pending = 8'h00; sidx = 0; end
            end
            default: begin pending = 8'h00; sidx = 0; end
         endcase
      end
   endtask

   // Byte engine model: random latency, one-cycle done, reply shifted by one transfer.
   initial begin
      forever begin
         @(negedge clk);
         xfer_done = 1'b0;
         if (xfer_req && rst_n) begin
            repeat ($urandom % 3) @(negedge clk);
            xfer_rx = pending;
            if (loglen < 32) lg[loglen] = xfer_tx;
            loglen++;
            reply(xfer_tx);
            xfer_done = 1'b1;
         end
      end
   end

   // Tick source and poll spacing monitor (R3).
   always @(negedge clk) begin
      if (xfer_req && xfer_tx == 8'h06 && !seen06) begin
         if (have_prev)
            chk(ticks - prev_ticks >= P, "R3 poll spacing", ticks - prev_ticks, P);
         prev_ticks = ticks;
         have_prev = 1'b1;
      end
      seen06 = xfer_req && (xfer_tx == 8'h06);
      tick = 1'b0;
      div = (div + 1) % 4;
      if (tick_en && div == 0) begin
         tick = 1'b1;
         ticks++;
      end
   end

   logic [7:0]  exp_ea = 8'h00, exp_eb = 8'h00;
   logic [23:0] exp_mask = 24'h0;
   logic [4:0]  exp_idx = 5'h1F;

   task automatic do_poll(input logic [7:0] s, input logic [7:0] ea, input logic [7:0] eb,
                          input logic [23:0] m, input bit tick_off);
      logic [7:0] es [0:15];
      int elen = 0;
      bit bad, fin = 1'b0, dropped = 1'b0;
      int upds = 0;
      sc_status = s; sc_ea = ea; sc_eb = eb;
      sc_m[0] = m[7:0]; sc_m[1] = m[15:8]; sc_m[2] = m[23:16];
      loglen = 0;
      bad = s[5] || (s[4:0] >= 5'(NK) && s[4:0] != 5'h1F);
      es[elen++] = 8'h06; es[elen++] = 8'h00;
      if (bad) begin
         es[elen++] = 8'h0F; es[elen++] = 8'h0F;
      end else begin
         if (s[7]) begin
            es[elen++] = 8'h0B; es[elen++] = 8'h00; es[elen++] = 8'h0C; es[elen++] = 8'h00;
         end
         if (s[6]) begin
            es[elen++] = 8'h07; es[elen++] = 8'h00; es[elen++] = 8'h00; es[elen++] = 8'h00;
         end
      end
      if (tick_off) begin
         for (int n = 0; n < 2000 && loglen == 0; n++) @(negedge clk);
         tick_en = 1'b0;
      end
      for (int n = 0; n < 3000 && !fin; n++) begin
         @(negedge clk);
         if (status_upd) upds++;
         if (bad) begin
            if (!in_sync) dropped = 1'b1;
            if (dropped && in_sync) fin = 1'b1;
         end else if (status_upd) fin = 1'b1;
      end
      if (tick_off) chk(fin, "R6 follow-up needs no tick", fin, 1);
      else chk(fin, bad ? "R8 resync after bad status" : "R7 poll completes", fin, 1);
      chk(loglen == elen, "R4 transfer count", loglen, elen);
      for (int i = 0; i < elen && i < loglen; i++)
         chk(lg[i] == es[i], "R4 command order", lg[i], es[i]);
      if (bad) begin
         chk(lost_sync == 1'b1, "R8 lost flag set", lost_sync, 1);
         chk(upds == 0, "R8 no update strobe", upds, 0);
         chk(key_idx == exp_idx, "R8 index unchanged", key_idx, exp_idx);
      end else begin
         exp_idx = s[4:0];
         if (s[7]) begin exp_ea = ea; exp_eb = eb; end
         if (s[6]) exp_mask = m;
         chk(key_idx == exp_idx, "R4 key index", key_idx, exp_idx);
         chk(err_flag == s[7], "R4 error flag", err_flag, s[7]);
         chk(multi_flag == s[6], "R4 multi flag", multi_flag, s[6]);
         chk(err_code_a == exp_ea && err_code_b == exp_eb, "R5 error codes",
             {err_code_a, err_code_b}, {exp_ea, exp_eb});
         chk(key_mask == exp_mask, "R6 key bitmap", key_mask, exp_mask);
      end
      if (tick_off) tick_en = 1'b1;
   endtask

   initial begin
      void'($urandom(32'd4242));
      repeat (4) @(negedge clk);
      chk(!in_sync && !lost_sync, "R2 reset flags", {in_sync, lost_sync}, 0);
      chk(key_idx == 5'h1F, "R2 reset index", key_idx, 5'h1F);
      chk(key_mask == 24'h0 && err_code_a == 8'h0 && err_code_b == 8'h0, "R2 reset data",
          key_mask, 0);
      chk(xfer_req && xfer_tx == 8'h0F, "R2 reset request", {xfer_req, xfer_tx}, 9'h10F);
      @(negedge clk);
      rst_n = 1'b1;
      for (int n = 0; n < 500 && !in_sync; n++) @(negedge clk);
      chk(in_sync, "R1 sync reached", in_sync, 1);
      chk(loglen == 5, "R1 resync attempts", loglen, 5);
      for (int i = 0; i < 5 && i < loglen; i++)
         chk(lg[i] == 8'h0F, "R1 resync byte", lg[i], 8'h0F);
      chk(!lost_sync, "R9 clear before loss", lost_sync, 0);
      sc_status = 8'h1F;
      tick_en = 1'b1;

      do_poll(8'h1F, 8'h00, 8'h00, 24'h0, 1'b0);
      do_poll(8'h03, 8'h00, 8'h00, 24'h0, 1'b0);
      do_poll(8'h80 | 8'd23, 8'h5A, 8'hC3, 24'h0, 1'b0);
      do_poll(8'h40, 8'h00, 8'h00, 24'h00F00F, 1'b0);
      do_poll(8'hC0 | 8'd9, 8'h11, 8'h22, 24'hA1B2C3, 1'b1);
      do_poll(8'h07, 8'h99, 8'h99, 24'hFFFFFF, 1'b0);
      do_poll(8'd24, 8'h00, 8'h00, 24'h0, 1'b0);
      do_poll(8'h05, 8'h00, 8'h00, 24'h0, 1'b0);
      chk(lost_sync, "R9 flag survives resync", lost_sync, 1);
      do_poll(8'h20 | 8'd2, 8'h00, 8'h00, 24'h0, 1'b0);
      do_poll(8'd30, 8'h00, 8'h00, 24'h0, 1'b0);
      for (int it = 0; it < 28; it++) begin
         logic [7:0] s;
         s[4:0] = ($urandom % 4 == 0) ? 5'h1F : 5'($urandom % NK);
         s[5] = 1'b0;
         s[6] = 1'($urandom);
         s[7] = 1'($urandom);
         do_poll(s, 8'($urandom), 8'($urandom), 24'($urandom), 1'b0);
      end
      chk(lost_sync, "R9 flag held to end", lost_sync, 1);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      nchk++;
      nerr++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule